// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. Each cycle it fetches a word from a word-addressed instruction store at the program counter. It decodes the word into datapath controls and reads two operands from a 32-entry register file. It computes a result in a small ALU and then does one of three things: writes the register file, writes a word-addressed data store, or redirects the program counter. The supported operations are register add and subtract, add-immediate, word load, word store, branch-if-equal, and a register-indexed load that reads the data store at the difference of two registers.

Both stores hold 256 words of 32 bits, so the program counter is 8 bits wide and advances by one word per instruction. While the synchronous reset is held, a preload port writes either store one word per cycle, and the core stays idle. After reset is released, execution starts at word 0. A set of trace outputs shows the current program counter and instruction, plus any register or data-store write the instruction commits at the next rising edge. A surrounding environment can follow execution from these outputs.

Top module: `cpu_core`

## Requirements
- R1: While reset is high at a rising edge, the program counter becomes 0 and every register is cleared to 0. The first instruction after reset is released is fetched from word 0.
- R2: An instruction that is not a taken branch moves the program counter to PC+1, wrapping modulo 256. The all-zero word commits no register or data-store write.
- R3: Opcode 000000 with function field 100000 writes rs+rt into rd, and function field 100010 writes rs-rt into rd. Both wrap modulo 2^32. Bit fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0].
- R4: Opcode 001000 writes rs plus the sign-extended 16-bit immediate [15:0] into rt. Bit 15 of the immediate is copied into bits 31:16.
- R5: Opcode 100011 writes into rt the data-store word at the low 8 bits of rs plus the sign-extended immediate.
- R6: Opcode 101011 writes rt into the data store at the low 8 bits of rs plus the sign-extended immediate, and writes no register. A later load from that address returns the stored word.
- R7: Opcode 000100 compares rs and rt. When they are equal, the next PC is PC+1 plus the low 8 bits of the sign-extended immediate, so a negative offset branches backwards. When they differ, the next PC is PC+1.
- R8: Opcode 000001 writes into rd the data-store word at the low 8 bits of rs minus rt. The subtraction wraps when rt is larger than rs.
- R9: Register 0 always reads 0. A write aimed at it commits nothing and drives no register-write strobe.
- R10: While reset is high, the preload port writes the instruction store or the data store at the preload address. The core commits no register or data-store write, and the program counter stays 0.
- R11: Any other opcode, and opcode 000000 with any other function field, commits no write and moves the PC to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| pre_imem_we | input | 1 | Preload write strobe for the instruction store |
| pre_dmem_we | input | 1 | Preload write strobe for the data store |
| pre_addr | input | 8 | Preload word address |
| pre_wdata | input | 32 | Preload word |
| pc_o | output | 8 | Current program counter |
| instr_o | output | 32 | Instruction word being executed |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dm_we_o | output | 1 | A data-store write commits at the next edge |
| dm_addr_o | output | 8 | Data-store address of the current access |
| dm_wdata_o | output | 32 | Word written to the data store |

## Verification
Three situations are hard to reach from the ports alone. The first is a backward branch whose target lies below the branch itself. The second is a register-indexed load whose address wraps below zero. The third is a load that must return a word stored earlier by the program rather than a preloaded one. The stimulus program builds a counting loop that closes with an always-equal branch of offset -3 and leaves it through a forward branch on a register match. It stores a negative word and reads it back through a zero base register, and it issues the indexed load with rt greater than rs, so the address is 251. An instruction-level model in the bench predicts every committed write and program-counter value for the whole run.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN   = 32;
    localparam int MEM_AW = 8;
    localparam int REG_AW = 5;
    localparam int IMM_W  = 16;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LDIDX = 6'b000001;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;

    typedef enum logic [3:0] {
        ALU_AND = 4'd0,
        ALU_OR  = 4'd1,
        ALU_ADD = 4'd2,
        ALU_SUB = 4'd6,
        ALU_SLT = 4'd7,
        ALU_NOR = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] fn;
    } instr_t;

    typedef struct packed {
        logic    dst_rd;
        logic    alu_imm;
        logic    mem_to_reg;
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        dst_rd: 1'b0, alu_imm: 1'b0, mem_to_reg: 1'b0, reg_write: 1'b0,
        mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0, alu_op: ALU_AND
    };

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] fn,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (op)
            OP_RTYPE: begin
                if (fn == FN_ADD || fn == FN_SUB) begin
                    ctrl.dst_rd    = 1'b1;
                    ctrl.reg_write = 1'b1;
                    ctrl.alu_op    = (fn == FN_ADD) ? ALU_ADD : ALU_SUB;
                end
            end
            OP_ADDI: begin
                ctrl.alu_imm   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            OP_LW: begin
                ctrl.alu_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            OP_SW: begin
                ctrl.alu_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_LDIDX: begin
                ctrl.dst_rd     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.alu_op     = ALU_SUB;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = (a < b) ? DW'(1) : '0;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    // R9: the hard-wired zero register never leaves zero
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

endmodule

// File: rtl/cpu_wordmem.sv
module cpu_wordmem #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          sel_n,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = sel_n ? '0 : mem[raddr];

    // R6: a word written at one edge is read back at the next cycle
    p_write_readback_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !sel_n && raddr == $past(waddr)) |-> rdata == $past(wdata));

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int XW  = XLEN,
    parameter int MAW = MEM_AW,
    parameter int RAW = REG_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_imem_we,
    input  logic           pre_dmem_we,
    input  logic [MAW-1:0] pre_addr,
    input  logic [XW-1:0]  pre_wdata,
    output logic [MAW-1:0] pc_o,
    output logic [XW-1:0]  instr_o,
    output logic           rf_we_o,
    output logic [RAW-1:0] rf_waddr_o,
    output logic [XW-1:0]  rf_wdata_o,
    output logic           dm_we_o,
    output logic [MAW-1:0] dm_addr_o,
    output logic [XW-1:0]  dm_wdata_o
);

    logic [MAW-1:0] pc_q, pc_inc, pc_next, br_off;
    logic [XW-1:0]  ins_word, imm_x, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
    logic [RAW-1:0] wb_addr;
    logic           alu_zero, take, rf_we;
    logic           dm_we;
    logic [MAW-1:0] dm_waddr;
    logic [XW-1:0]  dm_wdata;
    instr_t         ins;
    ctrl_t          ctrl;

    // instruction fetch; selected whenever the core runs
    cpu_wordmem #(.DW(XW), .AW(MAW)) u_imem (
        .clk   (clk),
        .rst   (rst),
        .we    (pre_imem_we & rst),
        .waddr (pre_addr),
        .wdata (pre_wdata),
        .sel_n (rst),
        .raddr (pc_q),
        .rdata (ins_word)
    );

    assign ins = instr_t'(ins_word);

    cpu_decode u_dec (
        .op   (ins.op),
        .fn   (ins.fn),
        .ctrl (ctrl)
    );

    assign wb_addr = ctrl.dst_rd ? ins.rd : ins.rt;
    assign rf_we   = ctrl.reg_write & ~rst;

    cpu_regfile #(.DW(XW), .AW(RAW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (ins.rs),
        .ra2   (ins.rt),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    assign imm_x = XW'(sext_imm({ins.rd, ins.shamt, ins.fn}));
    assign alu_b = ctrl.alu_imm ? imm_x : rt_val;

    cpu_alu #(.DW(XW)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data store: preload owns the write port during reset
    assign dm_we    = rst ? pre_dmem_we : ctrl.mem_write;
    assign dm_waddr = rst ? pre_addr    : alu_y[MAW-1:0];
    assign dm_wdata = rst ? pre_wdata   : rt_val;

    cpu_wordmem #(.DW(XW), .AW(MAW)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .sel_n (~ctrl.mem_read),
        .raddr (alu_y[MAW-1:0]),
        .rdata (dm_rdata)
    );

    assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

    // next program counter
    assign take    = ctrl.branch & alu_zero;
    assign br_off  = imm_x[MAW-1:0];
    assign pc_inc  = pc_q + MAW'(1);
    assign pc_next = take ? pc_inc + br_off : pc_inc;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o       = pc_q;
    assign instr_o    = ins_word;
    assign rf_we_o    = rf_we & (wb_addr != '0);
    assign rf_waddr_o = wb_addr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctrl.mem_write & ~rst;
    assign dm_addr_o  = alu_y[MAW-1:0];
    assign dm_wdata_o = rt_val;

    // R10: no architectural write while reset holds the core
    always_comb begin
        if (rst) p_idle_in_reset_r10: assert (!rf_we_o && !dm_we_o);
    end

    // R2: sequential step when no branch is taken
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(take)) |-> pc_q == $past(pc_q) + MAW'(1));

    // R7: taken branch lands at PC+1+offset
    p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(take)) |-> pc_q == $past(pc_q) + MAW'(1) + $past(br_off));

    // R6: a store never also writes a register
    p_store_excl_r6: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);

endmodule

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;

    localparam int STEPS = 50;
    localparam int PLEN  = 23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_imem_we = 1'b0;
    logic        pre_dmem_we = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [31:0] pre_wdata = '0;
    logic [7:0]  pc_o;
    logic [31:0] instr_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [7:0]  dm_addr_o;
    logic [31:0] dm_wdata_o;

    always #2 clk = ~clk;

    cpu_core i_cpu_core (
        .clk(clk), .rst(rst),
        .pre_imem_we(pre_imem_we), .pre_dmem_we(pre_dmem_we),
        .pre_addr(pre_addr), .pre_wdata(pre_wdata),
        .pc_o(pc_o), .instr_o(instr_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    typedef struct {
        logic [7:0]  pc;
        logic        rf_we;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic        dm_we;
        logic [7:0]  daddr;
        logic [31:0] dwdata;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic  running = 1'b0;

    logic [31:0] prog   [PLEN];
    logic [31:0] m_imem [256];
    logic [31:0] m_dmem [256];
    logic [31:0] m_reg  [32];
    logic [7:0]  m_pc;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver side: instruction-level model producing the expected trace
    task automatic model_step();
        item_t       it;
        logic [31:0] w, simm, a;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        logic [7:0]  npc;
        w  = m_imem[m_pc];
        op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; fn = w[5:0];
        simm = {{16{w[15]}}, w[15:0]};
        it.pc = m_pc; it.rf_we = 1'b0; it.waddr = '0; it.wdata = '0;
        it.dm_we = 1'b0; it.daddr = '0; it.dwdata = '0;
        npc = m_pc + 8'd1;
        case (op)
            6'b000000: begin
                if (fn == 6'b100000) begin
                    it.rf_we = 1; it.waddr = rd; it.wdata = m_reg[rs] + m_reg[rt]; it.tag = "R3";
                end else if (fn == 6'b100010) begin
                    it.rf_we = 1; it.waddr = rd; it.wdata = m_reg[rs] - m_reg[rt]; it.tag = "R3";
                end else begin
                    it.tag = (w == '0) ? "R2" : "R11";
                end
            end
            6'b001000: begin
                it.rf_we = 1; it.waddr = rt; it.wdata = m_reg[rs] + simm; it.tag = "R4";
            end
            6'b100011: begin
                a = m_reg[rs] + simm;
                it.rf_we = 1; it.waddr = rt; it.wdata = m_dmem[a[7:0]]; it.tag = "R5";
            end
            6'b101011: begin
                a = m_reg[rs] + simm;
                it.dm_we = 1; it.daddr = a[7:0]; it.dwdata = m_reg[rt]; it.tag = "R6";
            end
            6'b000100: begin
                if (m_reg[rs] == m_reg[rt]) npc = m_pc + 8'd1 + simm[7:0];
                it.tag = "R7";
            end
            6'b000001: begin
                a = m_reg[rs] - m_reg[rt];
                it.rf_we = 1; it.waddr = rd; it.wdata = m_dmem[a[7:0]]; it.tag = "R8";
            end
            default: it.tag = "R11";
        endcase
        if (it.rf_we && it.waddr == 5'd0) begin
            it.rf_we = 1'b0; it.tag = "R9";
        end
        if (it.rf_we) m_reg[it.waddr] = it.wdata;
        if (it.dm_we) m_dmem[it.daddr] = it.dwdata;
        m_pc = npc;
        sb_q.push_back(it);
    endtask

    // monitor: pop one expected item per executed instruction
    initial begin
        forever begin
            @(negedge clk);
            if (running && sb_q.size() > 0) begin
                item_t e;
                bit ok;
                #1;
                e = sb_q.pop_front();
                ok = (pc_o == e.pc) && (rf_we_o == e.rf_we) && (dm_we_o == e.dm_we);
                if (e.rf_we) ok = ok && (rf_waddr_o == e.waddr) && (rf_wdata_o == e.wdata);
                if (e.dm_we) ok = ok && (dm_addr_o == e.daddr) && (dm_wdata_o == e.dwdata);
                check(ok, e.tag, $sformatf("pc %0d trace{pc,rfwe,wa,wd,dmwe,da,dd}", e.pc),
                      {pc_o, 3'b0, rf_we_o, dm_we_o, rf_waddr_o, rf_wdata_o[13:0]},
                      {e.pc, 3'b0, e.rf_we, e.dm_we, e.waddr, e.wdata[13:0]});
                if (!ok)
                    $display("  detail: act wd=%0h da=%0h dd=%0h exp wd=%0h da=%0h dd=%0h",
                             rf_wdata_o, dm_addr_o, dm_wdata_o, e.wdata, e.daddr, e.dwdata);
            end
        end
    end

    initial begin
        #(4 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        prog[0]  = enc_i(6'b001000, 0, 1, 5);          // r1 = 5
        prog[1]  = enc_i(6'b001000, 0, 2, -3);         // r2 = -3
        prog[2]  = enc_r(1, 2, 3, 6'b100000);          // r3 = r1 + r2 = 2
        prog[3]  = enc_r(2, 1, 4, 6'b100010);          // r4 = r2 - r1 = -8
        prog[4]  = enc_i(6'b001000, 0, 0, 7);          // write to r0 dropped
        prog[5]  = enc_r(0, 0, 5, 6'b100000);          // r5 = r0 + r0
        prog[6]  = enc_i(6'b100011, 1, 6, 3);          // r6 = dmem[8]
        prog[7]  = enc_r(1, 3, 7, 6'b000000) | {6'b000001, 26'd0}; // r7 = dmem[r1-r3]
        prog[8]  = enc_i(6'b101011, 3, 4, 4);          // dmem[6] = r4
        prog[9]  = enc_i(6'b100011, 0, 8, 6);          // r8 = dmem[6]
        prog[10] = enc_i(6'b000100, 1, 2, 5);          // not taken
        prog[11] = 32'h0000_0000;                      // nop
        prog[12] = enc_i(6'b000100, 3, 3, 2);          // taken to 15
        prog[13] = enc_i(6'b001000, 0, 9, 99);
        prog[14] = enc_i(6'b001000, 0, 9, 98);
        prog[15] = 32'hFC00_0000;                      // unknown opcode
        prog[16] = enc_r(1, 2, 11, 6'b100100);         // unknown function
        prog[17] = enc_i(6'b001000, 10, 10, 1);        // r10++
        prog[18] = enc_i(6'b000100, 10, 1, 1);         // exit loop when r10 == 5
        prog[19] = enc_i(6'b000100, 0, 0, -3);         // back to 17
        prog[20] = enc_r(0, 1, 14, 6'b000000) | {6'b000001, 26'd0}; // dmem[251]
        prog[21] = enc_r(1, 4, 15, 6'b100000);         // r15 = 5 + -8
        prog[22] = enc_i(6'b000100, 0, 0, -1);         // self loop

        for (int i = 0; i < 256; i++) begin
            m_imem[i] = (i < PLEN) ? prog[i] : 32'h0;
            m_dmem[i] = i * 10 + 1;
        end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;

        repeat (2) @(negedge clk);
        #1;
        check(pc_o == 8'd0, "R1", "pc in reset", {24'd0, pc_o}, 32'd0);
        check(!rf_we_o && !dm_we_o, "R1", "write strobes in reset",
              {30'd0, rf_we_o, dm_we_o}, 32'd0);

        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pre_imem_we = 1'b1; pre_dmem_we = 1'b0;
            pre_addr = i[7:0]; pre_wdata = m_imem[i];
        end
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pre_imem_we = 1'b0; pre_dmem_we = 1'b1;
            pre_addr = i[7:0]; pre_wdata = m_dmem[i];
            if (i == 100) begin
                #1;
                check(!rf_we_o && !dm_we_o, "R10", "write strobes during preload",
                      {30'd0, rf_we_o, dm_we_o}, 32'd0);
                check(pc_o == 8'd0, "R10", "pc during preload", {24'd0, pc_o}, 32'd0);
            end
        end
        @(negedge clk);
        pre_imem_we = 1'b0; pre_dmem_we = 1'b0;

        for (int k = 0; k < STEPS; k++) model_step();

        @(posedge clk);
        #1;
        rst = 1'b0;
        running = 1'b1;
        repeat (STEPS) @(negedge clk);
        #2;
        running = 1'b0;

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        check(pc_o == 8'd0, "R1", "pc after second reset", {24'd0, pc_o}, 32'd0);
        check(sb_q.size() == 0, "R2", "trace items left over", sb_q.size(), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule